// File: doc/BRIEF.md
# Capacitive Load Charging Sequencer

This block is the digital sequencer of a smart high-side switch that has to charge large bulk capacitors on its output. When the switch is turned on, the block can run a dedicated charging mode. In that mode the output stage ramps at a reduced slew rate and the die-temperature gradient trip point is lowered. After any thermal or overcurrent trip the block switches the output off, waits a cool-down interval and then turns it back on by itself, with no host action. Once the output-voltage comparator reports that the load has reached its threshold, the block leaves the charging mode and runs as an ordinary switch.

The whole charging episode is bounded by a mode timer, counted from entry and covering every retry. If the timer runs out while a trip is present, the block switches off and latches a diagnostic fault. A trip that occurs in ordinary operation latches a fault at once. A host configures the block through a small register write port: one bit enables the charging mode and one bit is a fault-clear strobe. A retry counter is exported as status.

Top module: `cap_charge_seq`

## Requirements
- R1: After synchronous active-low reset the gate enable is low, the fault flag is low, the diagnostic code is 0, the retry count is 0, the slew select is 0 (normal) and the active threshold is 80.
- R2: A turn-on (switch-on request high while off) enters charging mode if the wake indication is high at that moment, or if the enable bit is 1. The enable bit is loaded from bit 0 of every register write and resets to 1. Otherwise the turn-on goes straight to normal operation, with the gate on from the next cycle.
- R3: The slew select output is 1 (reduced) throughout charging mode, including the cool-down gaps. It is 0 in every other state.
- R4: A trip is the overcurrent flag, or a temperature value greater than or equal to the active threshold. The threshold is 30 in charging mode and 80 otherwise.
- R5: A trip in charging mode turns the gate off for exactly COOL_CYC cycles. The gate then turns back on without host action, and each such trip adds one to the retry count.
- R6: When the voltage-reached flag is high in charging mode, the block moves to normal operation on the next edge. This exit takes priority over a trip and over timer expiry in the same cycle.
- R7: The charging mode lasts at most MODE_CYC cycles from entry, across all retries. At expiry, a trip in the same cycle or an ongoing cool-down latches a fault with diagnostic code 2. Otherwise the block moves to normal operation.
- R8: A trip in normal operation turns the gate off and latches a fault with diagnostic code 1 on the next edge, with no retry.
- R9: A latched fault holds the gate off until a register write with bit 1 set or until the switch-on request goes low. The next turn-on then starts a fresh mode timer.
- R10: The retry count saturates at 255 and is cleared at each turn-on.
- R11: When the switch-on request goes low, the gate turns off on the next edge from any on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_on_i | input | 1 | Switch-on request |
| wake_i | input | 1 | Turn-on is a wake from sleep |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 2 | Bit 0 mode enable, bit 1 fault clear |
| vout_ok_i | input | 1 | Output voltage reached threshold |
| dtemp_i | input | TEMP_W | Differential die temperature, degrees C |
| ocp_i | input | 1 | Overcurrent flag |
| gate_en_o | output | 1 | Output stage enable |
| slew_red_o | output | 1 | 1 = reduced slew rate |
| trip_thr_o | output | TEMP_W | Active thermal trip threshold |
| fault_o | output | 1 | Latched fault |
| diag_o | output | 2 | 0 none, 1 normal-mode trip, 2 mode timeout |
| retry_cnt_o | output | 8 | Retries in current episode |

## Verification
The two functions that can collide in one cycle are auto-retry and the end of the mode timer. The bench provokes the collision by holding the overcurrent flag high with a cool-down of two cycles and a mode limit of 1000. Each gate-on cycle then trips on a multiple of three, so the last gate-on cycle is also the expiry cycle. The result is judged correct when the fault appears with code 2 exactly one edge after that cycle, no further retry occurs, and the saturated count of 255 remains. A second coincidence, the voltage-reached exit in the same cycle as a trip, must end in normal operation with no fault.

// File: rtl/clm_pkg.sv
package clm_pkg;
    localparam int RETRY_W = 8;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CL_ON,
        ST_CL_COOL,
        ST_NORM,
        ST_FAULT
    } clm_state_e;

    typedef enum logic [1:0] {
        DIAG_NONE      = 2'd0,
        DIAG_NORM_TRIP = 2'd1,
        DIAG_CL_TMO    = 2'd2
    } clm_diag_e;

    typedef struct packed {
        clm_state_e         state;
        clm_diag_e          diag;
        logic [RETRY_W-1:0] retry;
    } clm_regs_t;
endpackage

// File: rtl/clm_cfg.sv
module clm_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_i,
    input  logic [1:0] reg_wdata_i,
    output logic       cl_en_o,
    output logic       clr_o
);
    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (reg_wr_i) en_d = reg_wdata_i[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= en_d;
    end

    assign cl_en_o = en_q;
    assign clr_o   = reg_wr_i & reg_wdata_i[1];
endmodule

// File: rtl/clm_cnt.sv
module clm_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic done_o
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                        cnt_d = '0;
        else if (run_i && cnt_q != LAST)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == LAST);

    // R7 / R5: counter never passes its terminal value
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/clm_trip.sv
module clm_trip #(
    parameter int TEMP_W   = 8,
    parameter int THR_CL   = 30,
    parameter int THR_NORM = 80
) (
    input  logic              cl_mode_i,
    input  logic [TEMP_W-1:0] dtemp_i,
    input  logic              ocp_i,
    output logic [TEMP_W-1:0] thr_o,
    output logic              trip_o
);
    localparam logic [TEMP_W-1:0] THR_A = TEMP_W'(THR_CL);
    localparam logic [TEMP_W-1:0] THR_B = TEMP_W'(THR_NORM);

    always_comb begin
        thr_o  = cl_mode_i ? THR_A : THR_B;
        trip_o = ocp_i | (dtemp_i >= thr_o);
    end
endmodule

// File: rtl/cap_charge_seq.sv
module cap_charge_seq
    import clm_pkg::*;
#(
    parameter int TEMP_W   = 8,
    parameter int THR_CL   = 30,
    parameter int THR_NORM = 80,
    parameter int COOL_CYC = 16,
    parameter int MODE_CYC = 2000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_on_i,
    input  logic               wake_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_wdata_i,
    input  logic               vout_ok_i,
    input  logic [TEMP_W-1:0]  dtemp_i,
    input  logic               ocp_i,
    output logic               gate_en_o,
    output logic               slew_red_o,
    output logic [TEMP_W-1:0]  trip_thr_o,
    output logic               fault_o,
    output logic [1:0]         diag_o,
    output logic [RETRY_W-1:0] retry_cnt_o
);
    clm_regs_t r_d, r_q;
    logic cl_en, clr, trip, in_cl, cool_done, mode_exp;

    clm_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .cl_en_o(cl_en), .clr_o(clr)
    );

    assign in_cl = (r_q.state == ST_CL_ON) || (r_q.state == ST_CL_COOL);

    clm_trip #(.TEMP_W(TEMP_W), .THR_CL(THR_CL), .THR_NORM(THR_NORM)) u_trip (
        .cl_mode_i(in_cl), .dtemp_i(dtemp_i), .ocp_i(ocp_i),
        .thr_o(trip_thr_o), .trip_o(trip)
    );

    clm_cnt #(.LIMIT(COOL_CYC)) u_cool (
        .clk(clk), .rst_n(rst_n),
        .clr_i(r_q.state != ST_CL_COOL), .run_i(r_q.state == ST_CL_COOL),
        .done_o(cool_done)
    );

    clm_cnt #(.LIMIT(MODE_CYC)) u_mode (
        .clk(clk), .rst_n(rst_n),
        .clr_i(!in_cl), .run_i(in_cl), .done_o(mode_exp)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_OFF: begin
                if (sw_on_i) begin
                    r_d.retry = '0;
                    r_d.diag  = DIAG_NONE;
                    r_d.state = (wake_i || cl_en) ? ST_CL_ON : ST_NORM;
                end
            end
            ST_CL_ON: begin
                if (!sw_on_i)       r_d.state = ST_OFF;
                else if (vout_ok_i) r_d.state = ST_NORM;
                else if (mode_exp) begin
                    if (trip) begin
                        r_d.state = ST_FAULT;
                        r_d.diag  = DIAG_CL_TMO;
                    end else begin
                        r_d.state = ST_NORM;
                    end
                end else if (trip) begin
                    r_d.state = ST_CL_COOL;
                    if (r_q.retry != '1) r_d.retry = r_q.retry + 1'b1;
                end
            end
            ST_CL_COOL: begin
                if (!sw_on_i)       r_d.state = ST_OFF;
                else if (vout_ok_i) r_d.state = ST_NORM;
                else if (mode_exp) begin
                    r_d.state = ST_FAULT;
                    r_d.diag  = DIAG_CL_TMO;
                end else if (cool_done) r_d.state = ST_CL_ON;
            end
            ST_NORM: begin
                if (!sw_on_i) r_d.state = ST_OFF;
                else if (trip) begin
                    r_d.state = ST_FAULT;
                    r_d.diag  = DIAG_NORM_TRIP;
                end
            end
            ST_FAULT: begin
                if (clr || !sw_on_i) begin
                    r_d.state = ST_OFF;
                    r_d.diag  = DIAG_NONE;
                end
            end
            default: r_d.state = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_OFF;
            r_q.diag  <= DIAG_NONE;
            r_q.retry <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_en_o   = (r_q.state == ST_CL_ON) || (r_q.state == ST_NORM);
    assign slew_red_o  = in_cl;
    assign fault_o     = (r_q.state == ST_FAULT);
    assign diag_o      = r_q.diag;
    assign retry_cnt_o = r_q.retry;

    // R4: reduced slew always paired with the folded threshold
    assert_cl_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slew_red_o |-> (trip_thr_o == TEMP_W'(THR_CL)));

    // R8: a trip in normal operation latches code 1 next edge
    assert_norm_trip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_NORM && sw_on_i && trip) |=>
        (fault_o && !gate_en_o && diag_o == 2'd1));

    // R9: fault holds until clear strobe or request removal
    assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && sw_on_i && !clr) |=> fault_o);

    // R6: voltage-reached exit wins inside the charging mode
    assert_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cl && sw_on_i && vout_ok_i) |=> (gate_en_o && !slew_red_o && !fault_o));

    // R10: saturated count stays saturated until the next turn-on
    assert_retry_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_OFF && retry_cnt_o == '1) |=> (retry_cnt_o == '1));

    // R11: request removal turns the gate off
    assert_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_on_i) |=> !gate_en_o);
endmodule

// File: tb/cap_charge_seq_tb.sv
module cap_charge_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int COOL = 2;
    localparam int MODE = 1000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sw_on, wake, reg_wr, vout_ok, ocp;
    logic [1:0] wdata;
    logic [7:0] dtemp;
    logic       gate, slew, fault;
    logic [7:0] thr, retry;
    logic [1:0] diag;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_charge_seq #(.TEMP_W(8), .THR_CL(30), .THR_NORM(80),
                     .COOL_CYC(COOL), .MODE_CYC(MODE)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_on_i(sw_on), .wake_i(wake),
        .reg_wr_i(reg_wr), .reg_wdata_i(wdata), .vout_ok_i(vout_ok),
        .dtemp_i(dtemp), .ocp_i(ocp), .gate_en_o(gate), .slew_red_o(slew),
        .trip_thr_o(thr), .fault_o(fault), .diag_o(diag), .retry_cnt_o(retry)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] d);
        reg_wr = 1'b1; wdata = d;
        tick(1);
        reg_wr = 1'b0; wdata = 2'b00;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; sw_on = 0; wake = 0; reg_wr = 0; wdata = 0;
        vout_ok = 0; ocp = 0; dtemp = 0;
        tick(3);
        chk("R1 gate", gate, 0);  chk("R1 fault", fault, 0);
        chk("R1 diag", diag, 0);  chk("R1 retry", retry, 0);
        chk("R1 slew", slew, 0);  chk("R1 thr", thr, 80);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic t_normal_direct;
        reg_write(2'b00);                       // disable charging mode
        sw_on = 1; tick(1);
        chk("R2 direct gate", gate, 1);
        chk("R3 normal slew", slew, 0);
        chk("R4 normal thr", thr, 80);
        dtemp = 79; tick(1);
        chk("R4 below thr", gate, 1);
        dtemp = 80; tick(1);
        chk("R8 fault", fault, 1); chk("R8 diag", diag, 1); chk("R8 gate", gate, 0);
        dtemp = 0; tick(10);
        chk("R8 no retry", gate, 0); chk("R9 held", fault, 1);
        reg_write(2'b10);                       // clear, keep enable 0
        chk("R9 clear", fault, 0);
        tick(1);
        chk("R9 reon normal", gate, 1);
        sw_on = 0; tick(1);
        chk("R11 off", gate, 0);
    endtask

    task automatic t_wake_exit;
        sw_on = 1; wake = 1; tick(1);
        wake = 0;
        chk("R2 wake entry", slew, 1);
        chk("R4 cl thr", thr, 30);
        vout_ok = 1; dtemp = 50; tick(1);       // exit and trip together
        chk("R6 exit slew", slew, 0); chk("R6 gate", gate, 1); chk("R6 fault", fault, 0);
        vout_ok = 0; dtemp = 0;
        sw_on = 0; tick(1);
    endtask

    task automatic t_retry;
        reg_write(2'b01);
        sw_on = 1; tick(1);
        chk("R2 enabled entry", slew, 1);
        ocp = 1; tick(1);
        ocp = 0;
        chk("R5 off after trip", gate, 0); chk("R3 slew in cool", slew, 1);
        tick(COOL - 1);
        chk("R5 still cooling", gate, 0);
        tick(1);
        chk("R5 auto on", gate, 1); chk("R5 retry 1", retry, 1);
        dtemp = 30; tick(1);
        chk("R4 cl trip at 30", gate, 0); chk("R5 retry 2", retry, 2);
        dtemp = 0;
        sw_on = 0; tick(1);
        chk("R11 off in cool", gate, 0);
    endtask

    task automatic t_timeout_clean;
        sw_on = 1; tick(MODE);
        chk("R7 still cl", slew, 1);
        tick(1);
        chk("R7 to normal", slew, 0); chk("R7 gate", gate, 1); chk("R7 nofault", fault, 0);
        sw_on = 0; tick(1);
    endtask

    task automatic t_timeout_fault;
        ocp = 1; sw_on = 1; tick(MODE);
        chk("R7 before expiry", fault, 0);
        tick(1);
        chk("R7 fault", fault, 1); chk("R7 diag", diag, 2); chk("R7 gate", gate, 0);
        chk("R10 saturate", retry, 255);
        tick(5);
        chk("R9 held", fault, 1);
        ocp = 0; sw_on = 0; tick(1);
        chk("R9 release", fault, 0);
        sw_on = 1; tick(1);
        chk("R10 cleared", retry, 0);
        tick(MODE - 2);
        chk("R9 fresh timer", slew, 1);
        sw_on = 0; tick(1);
    endtask

    initial begin
        t_reset();
        t_normal_direct();
        t_wake_exit();
        t_retry();
        t_timeout_clean();
        t_timeout_fault();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule